// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block keeps the interrupt state of one processor core over a 256-entry vector space. Three bit vectors record which vectors are requested, which are being serviced, and whether each accepted request was level or edge triggered. From a programmable task priority and the highest vector in service it derives a processor priority. It then offers the highest requested vector to the core only when that vector's 16-vector class lies above the processor priority.

The core takes the offered vector with a one-cycle acknowledge strobe, which moves it from requested to in service. A later end-of-interrupt strobe retires the highest vector in service. One cycle afterwards the block reports that vector and whether it was level triggered, so an upstream interrupt router can rearm a level source. New requests arrive on an accept port. They are taken only while both a hardware enable and a software enable are high, and only if the same vector is not already pending. The port reports at once whether the request was taken.

Top module: `vprio_ctrl`

## Requirements
- R1: Vector number v is stored as bit v of each 256-bit state vector (word v[7:5], bit v[4:0]). An accepted vector is later offered on `int_vector` with exactly its own number, including vectors on either side of a 32-bit word boundary.
- R2: `ppr` equals `tpr` when tpr[7:4] >= top[7:4], where top is the highest in-service vector, or 0 if none is in service. Otherwise `ppr` equals {top[7:4], 4'h0}. `ppr` reflects the state from the cycle after any change.
- R3: `int_valid` is high only when a vector is pending and {highest_pending[7:4], 4'h0} is strictly greater than `ppr`. Vectors 0x00..0x0F can therefore never be offered.
- R4: `ack` while `int_valid` is high sets the in-service bit of the offered vector and clears its request bit, from the next cycle on.
- R5: `eoi` clears the highest in-service bit and that vector's trigger bit. In the next cycle, and for that cycle only, `eoi_done` is high, `eoi_vector` holds the vector, and `eoi_level` is 1 if it was level triggered and 0 if it was edge triggered. With nothing in service, `eoi` has no effect and `eoi_done` stays low.
- R6: An accept of a vector whose request bit is already set is dropped: `acc_ok` is 0 and the trigger bit is left unchanged. A taken accept sets the trigger bit when `acc_level`=1 and clears it when `acc_level`=0.
- R7: When `hw_en` or `sw_en` is low, accepts are discarded with `acc_ok`=0 and leave the request state unchanged.
- R8: `tpr_we` loads `tpr_wdata` into the task priority, and `ppr` is recomputed from the new value in the next cycle.
- R9: Reset clears all request, in-service and trigger bits and the task priority, so `ppr` is 0, `int_valid` is 0 and `eoi_done` is 0.
- R10: Among several pending vectors, the numerically highest is the one offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_en | input | 1 | Hardware enable |
| sw_en | input | 1 | Software enable |
| acc_valid | input | 1 | Accept request strobe |
| acc_vector | input | 8 | Vector to accept |
| acc_level | input | 1 | 1 = level triggered, 0 = edge triggered |
| acc_ok | output | 1 | Accept taken this cycle |
| tpr_we | input | 1 | Task priority write strobe |
| tpr_wdata | input | 8 | Task priority value |
| ack | input | 1 | Core takes the offered vector |
| eoi | input | 1 | End-of-interrupt strobe |
| int_valid | output | 1 | A vector is deliverable |
| int_vector | output | 8 | Highest pending vector |
| ppr | output | 8 | Processor priority |
| eoi_done | output | 1 | One-cycle retire notification |
| eoi_vector | output | 8 | Vector that was retired |
| eoi_level | output | 1 | Retired vector was level triggered |

## Verification
The assertions assume that `ack` is raised only while `int_valid` is high. They also assume that an accept and an end-of-interrupt touching the same trigger bit do not fall in the same cycle whenever a trigger-bit property is being checked. The stimulus meets both conditions: it raises one strobe per cycle and acknowledges only after it has seen `int_valid`. The sequences are built so that the offered vector, the processor priority and the retired vector are known at every step, including the cases where a pending class equals the priority exactly.

// File: rtl/vprio_pkg.sv
package vprio_pkg;
    localparam int DEF_VEC_W   = 8;
    localparam int DEF_WORD_W  = 32;
    localparam int DEF_CLASS_W = 4;
endpackage

// File: rtl/vprio_word_enc.sv
module vprio_word_enc #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  bits,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (bits[i]) begin
                idx = IW'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/vprio_find.sv
module vprio_find #(
    parameter int N = 256,
    parameter int W = 32
) (
    input  logic [N-1:0]         vec,
    output logic [$clog2(N)-1:0] top,
    output logic                 none
);
    localparam int NWORD  = N / W;
    localparam int IW     = $clog2(W);
    localparam int WSEL_W = $clog2(NWORD);

    logic [IW-1:0]    widx [NWORD];
    logic [NWORD-1:0] wany;

    genvar g;
    generate
        for (g = 0; g < NWORD; g++) begin : g_word
            vprio_word_enc #(.W(W), .IW(IW)) enc_i (
                .bits (vec[g*W +: W]),
                .idx  (widx[g]),
                .any  (wany[g])
            );
        end
    endgenerate

    always_comb begin
        top  = '0;
        none = 1'b1;
        for (int w = 0; w < NWORD; w++) begin
            if (wany[w]) begin
                top  = {WSEL_W'(w), widx[w]};
                none = 1'b0;
            end
        end
    end
endmodule

// File: rtl/vprio_ppr.sv
module vprio_ppr #(
    parameter int VW = 8,
    parameter int CW = 4
) (
    input  logic [VW-1:0] tpr,
    input  logic [VW-1:0] isr_top,
    input  logic          isr_none,
    output logic [VW-1:0] ppr
);
    logic [VW-1:0] isr_eff;

    always_comb begin
        isr_eff = isr_none ? '0 : isr_top;
        if (tpr[VW-1 -: CW] >= isr_eff[VW-1 -: CW])
            ppr = tpr;
        else
            ppr = {isr_eff[VW-1 -: CW], {(VW-CW){1'b0}}};
    end
endmodule

// File: rtl/vprio_ctrl.sv
module vprio_ctrl #(
    parameter int VEC_W   = vprio_pkg::DEF_VEC_W,
    parameter int WORD_W  = vprio_pkg::DEF_WORD_W,
    parameter int CLASS_W = vprio_pkg::DEF_CLASS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_en,
    input  logic             sw_en,
    input  logic             acc_valid,
    input  logic [VEC_W-1:0] acc_vector,
    input  logic             acc_level,
    output logic             acc_ok,
    input  logic             tpr_we,
    input  logic [VEC_W-1:0] tpr_wdata,
    input  logic             ack,
    input  logic             eoi,
    output logic             int_valid,
    output logic [VEC_W-1:0] int_vector,
    output logic [VEC_W-1:0] ppr,
    output logic             eoi_done,
    output logic [VEC_W-1:0] eoi_vector,
    output logic             eoi_level
);
    localparam int NV   = 1 << VEC_W;
    localparam int LO_W = VEC_W - CLASS_W;

    typedef struct packed {
        logic [NV-1:0]    irr;
        logic [NV-1:0]    isr;
        logic [NV-1:0]    tmr;
        logic [VEC_W-1:0] tpr;
        logic             done;
        logic [VEC_W-1:0] dvec;
        logic             dlvl;
    } state_t;

    state_t st_q, st_d;

    logic [VEC_W-1:0] irr_top, isr_top;
    logic             irr_none, isr_none;
    logic             deliver, enabled;

    vprio_find #(.N(NV), .W(WORD_W)) find_req_i (
        .vec (st_q.irr), .top (irr_top), .none (irr_none)
    );

    vprio_find #(.N(NV), .W(WORD_W)) find_svc_i (
        .vec (st_q.isr), .top (isr_top), .none (isr_none)
    );

    vprio_ppr #(.VW(VEC_W), .CW(CLASS_W)) ppr_i (
        .tpr (st_q.tpr), .isr_top (isr_top), .isr_none (isr_none), .ppr (ppr)
    );

    always_comb begin
        enabled = hw_en && sw_en;
        deliver = !irr_none &&
                  ({irr_top[VEC_W-1 -: CLASS_W], {LO_W{1'b0}}} > ppr);
        acc_ok  = acc_valid && enabled && !st_q.irr[acc_vector];

        st_d      = st_q;
        st_d.done = 1'b0;
        if (ack && deliver) begin
            st_d.isr[irr_top] = 1'b1;
            st_d.irr[irr_top] = 1'b0;
        end
        if (eoi && !isr_none) begin
            st_d.isr[isr_top] = 1'b0;
            st_d.tmr[isr_top] = 1'b0;
            st_d.done         = 1'b1;
            st_d.dvec         = isr_top;
            st_d.dlvl         = st_q.tmr[isr_top];
        end
        if (acc_ok) begin
            st_d.irr[acc_vector] = 1'b1;
            st_d.tmr[acc_vector] = acc_level;
        end
        if (tpr_we)
            st_d.tpr = tpr_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign int_valid  = deliver;
    assign int_vector = irr_top;
    assign eoi_done   = st_q.done;
    assign eoi_vector = st_q.dvec;
    assign eoi_level  = st_q.dlvl;

    AST_PPR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        ppr[VEC_W-1 -: CLASS_W] >= st_q.tpr[VEC_W-1 -: CLASS_W]); // R2
    AST_DELIVER_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        int_valid |-> ({int_vector[VEC_W-1 -: CLASS_W], {LO_W{1'b0}}} > ppr)); // R3
    AST_ACK_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && int_valid) |=> (st_q.isr[$past(int_vector)] && !st_q.irr[$past(int_vector)])); // R4
    AST_EOI_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && st_q.isr == '0) |=> !eoi_done); // R5
    AST_EOI_RETIRED: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_done |-> !st_q.isr[eoi_vector]); // R5
    AST_DUP_KEEPS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && st_q.irr[acc_vector] && !eoi) |=>
        (st_q.tmr[$past(acc_vector)] == $past(st_q.tmr[acc_vector]))); // R6
    AST_DISABLED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !(hw_en && sw_en) && !st_q.irr[acc_vector]) |=>
        !st_q.irr[$past(acc_vector)]); // R7
    AST_TPR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        tpr_we |=> (st_q.tpr == $past(tpr_wdata))); // R8
endmodule

// File: tb/vprio_ctrl_tb.sv
module vprio_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n, hw_en, sw_en, acc_valid, acc_level, acc_ok;
    logic       tpr_we, ack, eoi, int_valid, eoi_done, eoi_level;
    logic [7:0] acc_vector, tpr_wdata, int_vector, ppr, eoi_vector;
    int         n_chk = 0, n_bad = 0;
    logic       last_ok;

    always #5 clk = ~clk;

    vprio_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .sw_en(sw_en),
        .acc_valid(acc_valid), .acc_vector(acc_vector), .acc_level(acc_level),
        .acc_ok(acc_ok), .tpr_we(tpr_we), .tpr_wdata(tpr_wdata), .ack(ack),
        .eoi(eoi), .int_valid(int_valid), .int_vector(int_vector), .ppr(ppr),
        .eoi_done(eoi_done), .eoi_vector(eoi_vector), .eoi_level(eoi_level)
    );

    // op: 0 accept, 1 ack, 2 eoi, 3 tpr write
    // {op, data, lvl, exp_valid, exp_vec, exp_ppr, exp_done, exp_lvl}
    localparam logic [29:0] TBL [17] = '{
        {2'd0, 8'h45, 1'b0, 1'b1, 8'h45, 8'h00, 1'b0, 1'b0},
        {2'd0, 8'h92, 1'b1, 1'b1, 8'h92, 8'h00, 1'b0, 1'b0},
        {2'd0, 8'h31, 1'b0, 1'b1, 8'h92, 8'h00, 1'b0, 1'b0},
        {2'd1, 8'h00, 1'b0, 1'b0, 8'h00, 8'h90, 1'b0, 1'b0},
        {2'd3, 8'hA7, 1'b0, 1'b0, 8'h00, 8'hA7, 1'b0, 1'b0},
        {2'd3, 8'h00, 1'b0, 1'b0, 8'h00, 8'h90, 1'b0, 1'b0},
        {2'd2, 8'h00, 1'b0, 1'b1, 8'h45, 8'h00, 1'b1, 1'b1},
        {2'd1, 8'h00, 1'b0, 1'b0, 8'h00, 8'h40, 1'b0, 1'b0},
        {2'd0, 8'h4F, 1'b0, 1'b0, 8'h00, 8'h40, 1'b0, 1'b0},
        {2'd0, 8'h50, 1'b1, 1'b1, 8'h50, 8'h40, 1'b0, 1'b0},
        {2'd1, 8'h00, 1'b0, 1'b0, 8'h00, 8'h50, 1'b0, 1'b0},
        {2'd2, 8'h00, 1'b0, 1'b0, 8'h00, 8'h40, 1'b1, 1'b1},
        {2'd2, 8'h00, 1'b0, 1'b1, 8'h4F, 8'h00, 1'b1, 1'b0},
        {2'd2, 8'h00, 1'b0, 1'b1, 8'h4F, 8'h00, 1'b0, 1'b0},
        {2'd3, 8'h3C, 1'b0, 1'b1, 8'h4F, 8'h3C, 1'b0, 1'b0},
        {2'd3, 8'h40, 1'b0, 1'b0, 8'h00, 8'h40, 1'b0, 1'b0},
        {2'd3, 8'h3F, 1'b0, 1'b1, 8'h4F, 8'h3F, 1'b0, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_acc(input logic [7:0] v, input logic lvl);
        acc_valid = 1'b1; acc_vector = v; acc_level = lvl;
        #1 last_ok = acc_ok;
        step();
        acc_valid = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1; step(); ack = 1'b0;
    endtask

    task automatic do_eoi();
        eoi = 1'b1; step(); eoi = 1'b0;
    endtask

    task automatic do_tpr(input logic [7:0] v);
        tpr_we = 1'b1; tpr_wdata = v; step(); tpr_we = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; step(); step(); rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        hw_en = 1'b1; sw_en = 1'b1; acc_valid = 1'b0; acc_vector = '0;
        acc_level = 1'b0; tpr_we = 1'b0; tpr_wdata = '0; ack = 1'b0; eoi = 1'b0;
        last_ok = 1'b0;
        do_reset();
        check("R9 valid after reset", int_valid, 0);
        check("R9 ppr after reset", ppr, 0);
        check("R9 eoi_done after reset", eoi_done, 0);

        for (int i = 0; i < 17; i++) begin
            logic [29:0] e;
            e = TBL[i];
            case (e[29:28])
                2'd0: do_acc(e[27:20], e[19]);
                2'd1: do_ack();
                2'd2: do_eoi();
                default: do_tpr(e[27:20]);
            endcase
            check("R3 table int_valid", int_valid, e[18]);
            if (e[18]) check("R10 table int_vector", int_vector, e[17:10]);
            check("R2 table ppr", ppr, e[9:2]);
            check("R5 table eoi_done", eoi_done, e[1]);
            if (e[1]) check("R5 table eoi_level", eoi_level, e[0]);
        end

        // reset clears pending 0x4F and tpr 0x3F
        do_reset();
        check("R9 pending cleared", int_valid, 0);
        check("R9 tpr cleared", ppr, 0);

        do_acc(8'h0F, 1'b0);
        check("R3 class 0 accept ok", last_ok, 1);
        check("R3 class 0 never offered", int_valid, 0);
        do_acc(8'h1F, 1'b0);
        check("R1 vector 0x1F", int_vector, 8'h1F);
        do_acc(8'h20, 1'b0);
        check("R1 word boundary 0x20", int_vector, 8'h20);
        do_acc(8'hFF, 1'b0);
        check("R10 top vector 0xFF", int_vector, 8'hFF);
        do_ack();
        do_eoi();
        check("R5 retired vector", eoi_vector, 8'hFF);
        check("R5 retired edge", eoi_level, 0);
        step();
        check("R5 done one cycle", eoi_done, 0);

        do_acc(8'h70, 1'b1);
        check("R6 first accept ok", last_ok, 1);
        do_acc(8'h70, 1'b0);
        check("R6 duplicate dropped", last_ok, 0);
        do_ack();
        do_eoi();
        check("R6 trigger kept level", eoi_level, 1);
        check("R5 vector 0x70", eoi_vector, 8'h70);

        sw_en = 1'b0;
        do_acc(8'h90, 1'b0);
        check("R7 sw disabled acc_ok", last_ok, 0);
        check("R7 sw disabled no request", int_vector, 8'h20);
        sw_en = 1'b1; hw_en = 1'b0;
        do_acc(8'hA0, 1'b0);
        check("R7 hw disabled acc_ok", last_ok, 0);
        check("R7 hw disabled no request", int_vector, 8'h20);
        hw_en = 1'b1;
        do_acc(8'h90, 1'b0);
        check("R7 enabled accept", int_vector, 8'h90);

        do_tpr(8'h95);
        check("R8 tpr equal class", ppr, 8'h95);
        check("R3 equal class blocked", int_valid, 0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule